// File: doc/BRIEF.md
# Dual Prescaled Down-Counter Timers

This block contains two independent 8-bit down-counting timers. Each timer has its own 6-bit prescaler. A small register port lets software store an initial count and a prescaler setting for each timer, start and stop counting, force a reload, and read the live count at any time. Each timer raises its own interrupt request when it reaches the end of its count. In single-pass operation the timer then stops. In modulo operation it reloads and keeps going, which gives a periodic tick.

Timer 0 always counts an internal tick, which is the system clock divided by four. Timer 1 can count the same internal tick, or it can take its timing from an external input. That input is brought into the clock domain through a two-stage synchroniser and an edge detector. In external mode the input can act in four ways: each rising edge is one count, it can gate the internal tick, it can start a one-shot that ignores later edges, or it can start a one-shot that restarts on every edge.

Top module: `dual_prescaled_timer`

## Requirements
- R1: After reset, both timers are disabled and hold count 0, all stored settings are 0, reads of the control and count addresses return 0, and both interrupt outputs are low.
- R2: The write addresses are as follows. Address 0 is control: bit0 loads timer 0, bit1 enables timer 0, bit2 loads timer 1, bit3 enables timer 1, and bits 5:4 select the input mode. Addresses 1 and 3 hold the initial counts of timers 0 and 1. Addresses 2 and 4 hold the prescaler configuration: [7:2] is the divide value, [0] selects modulo when 1, and [1] selects the internal source for timer 1 when 1. A read of address 0 returns control with the load bits as 0. Reads of 1 and 3 return the live counts. Every other address, including the prescaler addresses, reads 0.
- R3: On the internal source, a modulo timer with divide value P and initial count N ends its count once every 4·P·N clock cycles.
- R4: A divide code of 0 acts as 64 and a count code of 0 acts as 256.
- R5: In single-pass mode, the end of count leaves the count at 0 and clears that timer's enable bit. The exception is timer 1 in a trigger mode, covered by R12.
- R6: In modulo mode, the end of count reloads the stored initial count and counting continues.
- R7: Setting a load bit copies the stored initial count and divide value into that timer. Writing an initial count alone does not change the live count.
- R8: While a timer's enable bit is 0 its count holds. Reading the count never disturbs it.
- R9: When timer 1 selects the internal source, the external input has no effect.
- R10: In input mode 00 (external source), each synchronised rising edge of the input is one prescaler step.
- R11: In input mode 01 (external source), timer 1 counts internal ticks only while the synchronised input is high.
- R12: In input mode 10, a rising edge loads timer 1 and starts it. Edges are ignored while it runs. A single-pass end stops the run and leaves the enable bit set, so a new edge starts it again.
- R13: In input mode 11, every rising edge reloads timer 1 from its stored values and (re)starts it.
- R14: Each end of count gives a one-cycle-high pulse on that timer's interrupt output in the cycle after the step that reached it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| ext_in | input | 1 | External timing input for timer 1 (asynchronous) |
| irq_t0 | output | 1 | End-of-count pulse of timer 0 |
| irq_t1 | output | 1 | End-of-count pulse of timer 1 |

## Verification
The assertions check the following on every cycle: the interrupt pulse is one cycle wide, the count holds when there is no step and no load, the counter reaches 0 or reloads at the end of count, a load copies the stored values, a single-pass end clears the enable, and a gated-off input freezes timer 1. The bench scenarios are needed for everything that depends on long spans of time: the exact 4·P·N period, the full-range meaning of zero codes, external edge counting through the synchroniser, and the difference between the two trigger modes. The trigger modes are told apart by the time from a burst of input edges to the interrupt.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // Register addresses
  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_T0_CNT = 3'd1;
  localparam logic [2:0] ADDR_T0_CFG = 3'd2;
  localparam logic [2:0] ADDR_T1_CNT = 3'd3;
  localparam logic [2:0] ADDR_T1_CFG = 3'd4;

  // Control register bit positions
  localparam int CTRL_LOAD0    = 0;
  localparam int CTRL_EN0      = 1;
  localparam int CTRL_LOAD1    = 2;
  localparam int CTRL_EN1      = 3;
  localparam int CTRL_MODE_LSB = 4;

  // Prescaler configuration bit positions
  localparam int CFG_MOD_BIT = 0;
  localparam int CFG_SRC_BIT = 1;
  localparam int CFG_DIV_LSB = 2;

  typedef enum logic [1:0] {
    EXT_CLOCK       = 2'b00,
    EXT_GATE        = 2'b01,
    EXT_TRIG_ONCE   = 2'b10,
    EXT_TRIG_RETRIG = 2'b11
  } ext_mode_e;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] div_q, div_nxt;

  always_comb begin
    tick    = (div_q == LAST);
    div_nxt = tick ? '0 : div_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nxt;
  end
endmodule

// File: rtl/ext_conditioner.sv
module ext_conditioner #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] sh_q, sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-1:0], ext_in};
    level  = sh_q[STAGES-1];
    rise   = sh_q[STAGES-1] & ~sh_q[STAGES];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  // R10: a synchronised edge is seen for exactly one cycle
  assert_rise_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/timer_channel.sv
module timer_channel #(
  parameter int CNT_W = 8,
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] init_cnt,
  input  logic [PRE_W-1:0] init_pre,
  input  logic             modulo,
  output logic [CNT_W-1:0] count,
  output logic             eoc,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic             irq_q;
  logic             pre_done, cnt_done;

  always_comb begin
    pre_done = (pre_q == PRE_ONE);
    cnt_done = (cnt_q == CNT_ONE);
    eoc      = step & ~load & pre_done & cnt_done;
    cnt_nxt  = cnt_q;
    pre_nxt  = pre_q;
    if (load) begin
      cnt_nxt = init_cnt;
      pre_nxt = init_pre;
    end else if (step) begin
      if (pre_done) begin
        pre_nxt = init_pre;
        if (cnt_done) cnt_nxt = modulo ? init_cnt : '0;
        else          cnt_nxt = cnt_q - CNT_ONE;
      end else begin
        pre_nxt = pre_q - PRE_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      pre_q <= pre_nxt;
      irq_q <= eoc;
    end
  end

  assign count = cnt_q;
  assign irq   = irq_q;

  assert_irq_one_cycle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_hold_without_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(count));
  assert_single_pass_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !modulo) |=> (count == '0));
  assert_modulo_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && modulo) |=> (count == $past(init_cnt)));
  assert_load_copies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(init_cnt)));
endmodule

// File: rtl/dual_prescaled_timer.sv
module dual_prescaled_timer
  import timer_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 6,
  parameter int TICK_DIV    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             ext_in,
  output logic             irq_t0,
  output logic             irq_t1
);
  localparam int NCH   = 2;
  localparam int CFG_W = PRE_W + CFG_DIV_LSB;

  logic                 tick, ext_level, ext_rise;
  logic [NCH-1:0]       en_q, en_nxt;
  ext_mode_e            mode_q, mode_nxt;
  logic                 trun_q, trun_nxt;
  logic [CNT_W-1:0]     init_q [NCH];
  logic [CFG_W-1:0]     cfg_q  [NCH];
  logic [CNT_W-1:0]     count  [NCH];
  logic [NCH-1:0]       load, step, eoc, irq, ext_step;
  logic                 wr_ctrl, trig_mode, arm_edge, rearm;
  logic [CNT_W-1:0]     ctrl_view;

  tick_divider #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  ext_conditioner #(.STAGES(SYNC_STAGES)) u_ext (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .level(ext_level), .rise(ext_rise));

  // Trigger / external step logic (timer 1 only)
  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
    trig_mode = !cfg_q[1][CFG_SRC_BIT] && mode_q[1];
    arm_edge  = trig_mode && en_q[1] && ext_rise;
    rearm     = arm_edge && ((mode_q == EXT_TRIG_RETRIG) || !trun_q);
    ext_step[0] = 1'b0;
    unique case (mode_q)
      EXT_CLOCK:       ext_step[1] = ext_rise;
      EXT_GATE:        ext_step[1] = tick && ext_level;
      EXT_TRIG_ONCE,
      EXT_TRIG_RETRIG: ext_step[1] = tick && trun_q;
    endcase
    load[0] = wr_ctrl && wr_data[CTRL_LOAD0];
    load[1] = (wr_ctrl && wr_data[CTRL_LOAD1]) || rearm;
  end

  // Per-timer settings and counter instances
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [2:0] A_CNT = (g == 0) ? ADDR_T0_CNT : ADDR_T1_CNT;
    localparam logic [2:0] A_CFG = (g == 0) ? ADDR_T0_CFG : ADDR_T1_CFG;
    localparam bit         HAS_EXT = (g == 1);
    localparam logic [CFG_W-1:0] SRC_MASK = CFG_W'(1) << CFG_SRC_BIT;
    localparam logic [CFG_W-1:0] CFG_RST  = HAS_EXT ? '0 : SRC_MASK;

    logic [CNT_W-1:0] init_nxt;
    logic [CFG_W-1:0] cfg_nxt;

    always_comb begin
      init_nxt = init_q[g];
      cfg_nxt  = cfg_q[g];
      if (wr_en && wr_addr == A_CNT) init_nxt = wr_data;
      if (wr_en && wr_addr == A_CFG)
        cfg_nxt = HAS_EXT ? wr_data[CFG_W-1:0] : (wr_data[CFG_W-1:0] | SRC_MASK);
      step[g] = en_q[g] && (cfg_q[g][CFG_SRC_BIT] ? tick : ext_step[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        init_q[g] <= '0;
        cfg_q[g]  <= CFG_RST;
      end else begin
        init_q[g] <= init_nxt;
        cfg_q[g]  <= cfg_nxt;
      end
    end

    timer_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[g]),
      .step     (step[g]),
      .init_cnt (init_q[g]),
      .init_pre (cfg_q[g][CFG_W-1:CFG_DIV_LSB]),
      .modulo   (cfg_q[g][CFG_MOD_BIT]),
      .count    (count[g]),
      .eoc      (eoc[g]),
      .irq      (irq[g]));
  end

  // Control register next state
  always_comb begin
    en_nxt   = en_q;
    mode_nxt = mode_q;
    trun_nxt = trun_q;
    if (wr_ctrl) begin
      en_nxt[0] = wr_data[CTRL_EN0];
      en_nxt[1] = wr_data[CTRL_EN1];
      mode_nxt  = ext_mode_e'(wr_data[CTRL_MODE_LSB +: 2]);
    end else begin
      if (eoc[0] && !cfg_q[0][CFG_MOD_BIT]) en_nxt[0] = 1'b0;
      if (eoc[1] && !cfg_q[1][CFG_MOD_BIT] && !trig_mode) en_nxt[1] = 1'b0;
    end
    if (wr_ctrl && !wr_data[CTRL_EN1])                      trun_nxt = 1'b0;
    else if (eoc[1] && !cfg_q[1][CFG_MOD_BIT] && trig_mode) trun_nxt = 1'b0;
    else if (rearm)                                         trun_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= EXT_CLOCK;
      trun_q <= 1'b0;
    end else begin
      en_q   <= en_nxt;
      mode_q <= mode_nxt;
      trun_q <= trun_nxt;
    end
  end

  // Read mux
  always_comb begin
    ctrl_view = '0;
    ctrl_view[CTRL_EN0] = en_q[0];
    ctrl_view[CTRL_EN1] = en_q[1];
    ctrl_view[CTRL_MODE_LSB +: 2] = mode_q;
    unique case (rd_addr)
      ADDR_CTRL:   rd_data = ctrl_view;
      ADDR_T0_CNT: rd_data = count[0];
      ADDR_T1_CNT: rd_data = count[1];
      default:     rd_data = '0;
    endcase
  end

  assign irq_t0 = irq[0];
  assign irq_t1 = irq[1];

  assert_single_pass_disables_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc[0] && !cfg_q[0][CFG_MOD_BIT] && !wr_ctrl) |=> !en_q[0]);
  assert_trigger_keeps_enable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc[1] && !cfg_q[1][CFG_MOD_BIT] && trig_mode && !wr_ctrl) |=> (en_q[1] && !trun_q));
  assert_gate_low_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[1][CFG_SRC_BIT] && mode_q == EXT_GATE && !ext_level && !load[1])
      |=> $stable(count[1]));
  assert_disabled_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q[0] && !load[0]) |=> $stable(count[0]));
endmodule

// File: tb/dual_prescaled_timer_tb_top.sv
`timescale 1ns/100ps
module dual_prescaled_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_in = 1'b0;
  logic       irq_t0, irq_t1;

  always #2.5 clk = ~clk;

  dual_prescaled_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_in(ext_in),
    .irq_t0(irq_t0), .irq_t1(irq_t1));

  int    n_checks = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference model
  int m_cnt[2], m_pre[2], m_ini[2], m_cfg[2];
  bit m_en[2], m_irq[2], m_eoc[2];
  int m_mode, m_div;
  bit m_trun, m_s1, m_s2, m_s3;
  bit t_tick, t_rise, t_wc, t_int, t_trg, t_rel, t_st, t_ld;

  function automatic int m_read(int a);
    case (a)
      0: return (m_mode << 4) | (int'(m_en[1]) << 3) | (int'(m_en[0]) << 1);
      1: return m_cnt[0];
      3: return m_cnt[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_cnt[c] = 0; m_pre[c] = 0; m_ini[c] = 0; m_cfg[c] = 0;
        m_en[c] = 0; m_irq[c] = 0; m_eoc[c] = 0;
      end
      m_mode = 0; m_div = 0; m_trun = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      cyc++;
      t_tick = (m_div == 3);
      t_rise = m_s2 && !m_s3;
      t_wc   = wr_en && wr_addr == 3'd0;
      t_int  = m_cfg[1][1];
      t_trg  = !t_int && m_mode >= 2;
      t_rel  = t_trg && m_en[1] && t_rise && (m_mode == 3 || !m_trun);
      for (int c = 0; c < 2; c++) begin
        if (c == 0) begin
          t_st = m_en[0] && t_tick;
          t_ld = t_wc && wr_data[0];
        end else begin
          if (t_int) t_st = m_en[1] && t_tick;
          else case (m_mode)
            0: t_st = m_en[1] && t_rise;
            1: t_st = m_en[1] && t_tick && m_s2;
            default: t_st = m_en[1] && t_tick && m_trun;
          endcase
          t_ld = (t_wc && wr_data[2]) || t_rel;
        end
        m_eoc[c] = 0;
        if (t_ld) begin
          m_cnt[c] = m_ini[c]; m_pre[c] = m_cfg[c] >> 2;
        end else if (t_st) begin
          if (m_pre[c] == 1) begin
            m_pre[c] = m_cfg[c] >> 2;
            if (m_cnt[c] == 1) begin
              m_eoc[c] = 1;
              m_cnt[c] = m_cfg[c][0] ? m_ini[c] : 0;
            end else m_cnt[c] = (m_cnt[c] + 255) % 256;
          end else m_pre[c] = (m_pre[c] + 63) % 64;
        end
        m_irq[c] = m_eoc[c];
      end
      if (t_wc) begin
        m_en[0] = wr_data[1]; m_en[1] = wr_data[3]; m_mode = int'(wr_data[5:4]);
      end else begin
        if (m_eoc[0] && !m_cfg[0][0]) m_en[0] = 0;
        if (m_eoc[1] && !m_cfg[1][0] && !t_trg) m_en[1] = 0;
      end
      if (t_wc && !wr_data[3]) m_trun = 0;
      else if (m_eoc[1] && !m_cfg[1][0] && t_trg) m_trun = 0;
      else if (t_rel) m_trun = 1;
      if (wr_en) case (wr_addr)
        3'd1: m_ini[0] = int'(wr_data);
        3'd2: m_cfg[0] = int'(wr_data);
        3'd3: m_ini[1] = int'(wr_data);
        3'd4: m_cfg[1] = int'(wr_data);
        default: ;
      endcase
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_in;
      m_div = (m_div + 1) % 4;
    end
  end

  // Per-cycle comparison and irq bookkeeping
  int irq_cnt0 = 0, irq_cnt1 = 0, last0 = 0, prev0 = 0, last1 = 0, prev1 = 0;
  bit hi0 = 0, hi1 = 0;
  int dbl = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks += 3;
      if (irq_t0 !== m_irq[0]) begin
        n_fail++; $display("FAIL %s irq_t0: actual %0d expected %0d", cur_req, irq_t0, m_irq[0]);
      end
      if (irq_t1 !== m_irq[1]) begin
        n_fail++; $display("FAIL %s irq_t1: actual %0d expected %0d", cur_req, irq_t1, m_irq[1]);
      end
      if (int'(rd_data) != m_read(int'(rd_addr))) begin
        n_fail++; $display("FAIL %s rd_data@%0d: actual %0d expected %0d", cur_req, rd_addr, rd_data, m_read(int'(rd_addr)));
      end
      if (irq_t0) begin irq_cnt0++; prev0 = last0; last0 = cyc; if (hi0) dbl++; end
      if (irq_t1) begin irq_cnt1++; prev1 = last1; last1 = cyc; if (hi1) dbl++; end
      hi0 = irq_t0; hi1 = irq_t1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++; $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    n_checks++;
    if (act < lo || act > hi) begin
      n_fail++; $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    @(negedge clk);
    v = int'(rd_data);
    #1;
  endtask

  task automatic ext_pulses(input int n, input int hi, input int lo);
    for (int i = 0; i < n; i++) begin
      ext_in = 1'b1; repeat (hi) @(negedge clk); #1;
      ext_in = 1'b0; repeat (lo) @(negedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int v, k, s;
    // R1 reset state
    idle(3);
    chk("R1 irq_t0 in reset", int'(irq_t0), 0);
    rst_n = 1'b1;
    idle(2);
    rd(0, v); chk("R1 control after reset", v, 0);
    rd(1, v); chk("R1 timer0 count after reset", v, 0);
    rd(3, v); chk("R1 timer1 count after reset", v, 0);
    chk("R1 irq_t1 after reset", int'(irq_t1), 0);

    // R3 / R6 modulo period on timer 0, divide 3, count 5
    cur_req = "R6";
    wr(2, (3 << 2) | 1); wr(1, 5); wr(0, 8'h03);
    rd(2, v); chk("R2 prescaler address reads 0", v, 0);
    idle(200);
    chk("R3 period 4*3*5", last0 - prev0, 60);
    k = irq_cnt0; idle(60); chk("R6 modulo keeps producing", irq_cnt0 - k, 1);

    // R8 freeze when disabled, reads do not disturb
    cur_req = "R8";
    wr(0, 8'h00);
    rd(1, v); idle(40); rd(1, k);
    chk("R8 count frozen", k, v);
    rd(1, k); chk("R8 repeated read stable", k, v);

    // R5 single pass
    cur_req = "R5";
    wr(2, (2 << 2)); wr(1, 3);
    k = irq_cnt0; wr(0, 8'h03); idle(100);
    chk("R5 single pass one pulse", irq_cnt0 - k, 1);
    rd(0, v); chk("R5 enable cleared", v, 0);
    rd(1, v); chk("R5 count at 0", v, 0);

    // R7 load behaviour
    cur_req = "R7";
    wr(1, 9); rd(1, v); chk("R7 init write does not change count", v, 0);
    wr(0, 8'h01); rd(1, v); chk("R7 load copies init", v, 9);
    rd(0, v); chk("R2 load bit reads 0", v, 0);

    // R4 zero codes
    cur_req = "R4";
    wr(2, 8'h01); wr(1, 2); wr(0, 8'h03); idle(1100);
    chk("R4 divide code 0 is 64", last0 - prev0, 512);
    wr(0, 8'h00); wr(2, 8'h05); wr(1, 0); wr(0, 8'h03); idle(2100);
    chk("R4 count code 0 is 256", last0 - prev0, 1024);
    wr(0, 8'h00);

    // R9 internal source ignores external input
    cur_req = "R9";
    wr(4, 8'h07); wr(3, 4); wr(0, 8'h0C);
    for (int i = 0; i < 120; i++) begin ext_in = ~ext_in; @(negedge clk); #1; end
    ext_in = 1'b0;
    chk("R9 internal period with toggling input", last1 - prev1, 16);
    chk("R14 no back-to-back pulses", dbl, 0);

    // R10 external clock
    cur_req = "R10";
    wr(0, 8'h00); wr(4, 8'h05); wr(3, 3); wr(0, 8'h0C); idle(4);
    k = irq_cnt1; ext_pulses(6, 2, 2); idle(6);
    chk("R10 six edges, count 3 -> two pulses", irq_cnt1 - k, 2);

    // R11 gate
    cur_req = "R11";
    wr(0, 8'h00); wr(4, 8'h09); wr(3, 2); wr(0, 8'h1C);
    k = irq_cnt1; idle(100); chk("R11 no counting while low", irq_cnt1 - k, 0);
    ext_in = 1'b1; k = irq_cnt1; idle(200);
    chk_range("R11 counting while high", irq_cnt1 - k, 11, 13);
    chk("R11 gated period", last1 - prev1, 16);
    ext_in = 1'b0; idle(5); k = irq_cnt1; idle(100);
    chk("R11 stops when low again", irq_cnt1 - k, 0);

    // R12 non-retriggerable
    cur_req = "R12";
    wr(0, 8'h00); wr(4, 8'h04); wr(3, 10); wr(0, 8'h2C);
    k = irq_cnt1; s = cyc;
    ext_pulses(1, 3, 7); ext_pulses(2, 3, 7); idle(60);
    chk("R12 one pulse despite extra edges", irq_cnt1 - k, 1);
    chk_range("R12 timed from first edge", last1 - s, 38, 50);
    rd(0, v); chk("R12 enable kept after single pass", v, 8'h28);
    k = irq_cnt1; ext_pulses(1, 3, 7); idle(60);
    chk("R12 new edge restarts", irq_cnt1 - k, 1);

    // R13 retriggerable
    cur_req = "R13";
    wr(0, 8'h00); wr(0, 8'h3C);
    k = irq_cnt1;
    ext_pulses(4, 3, 17); s = cyc; ext_pulses(1, 3, 17);
    chk("R13 no pulse while retriggered", irq_cnt1 - k, 0);
    idle(60);
    chk("R13 one pulse after last edge", irq_cnt1 - k, 1);
    chk_range("R13 timed from last edge", last1 - s, 38, 50);
    chk("R14 pulses are one cycle wide", dbl, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule